// File: doc/BRIEF.md
# Dual-Clock Single-Word Bypass Bridge

This block carries single words directly between two processors that run on independent clocks, past the FIFO storage that normally sits between them. There are two one-word paths, one from side A to side B and one from side B to side A. Each path holds a written word in its input register until the opposite side reads it. While a word is held, further writes into that path are refused. Once the word has been read, the path is free again.

Side A alone decides when the bridge is in bypass mode. It does so through its chip select and a 3-bit address: address 3'b001 with chip select low selects bypass mode. A status flag carries that decision into the side B clock domain. Side B may move data only while that flag is high. The occupancy of each path crosses between the domains as toggle events. The held word is not re-timed, because it stays stable for as long as the reader can see it as valid.

Top module: `bypass_bridge`

## Requirements
- R1: While `rst_n` is low, `byp_flag`, `a_dout` and `b_dout` are all 0, and both paths are emptied.
- R2: When side A holds `a_cs_n`=0 and `a_addr`=3'b001, `byp_flag` becomes 1 within one `clk_a` rising edge followed by SYNC_STAGES `clk_b` rising edges.
- R3: When side A selects `a_addr`=3'b000, or raises `a_cs_n`, `byp_flag` returns to 0 within the same latency as R2.
- R4: A side A write captures `a_din` into the A-to-B path. A side A write is `a_cs_n`=0, `a_addr`=3'b001, `a_en`=1 and `a_write`=1 on a `clk_a` edge. A later side B read loads `b_dout` with that word. A side B read is `byp_flag`=1, `b_en`=1 and `b_write`=0 on a `clk_b` edge.
- R5: A side B write captures `b_din` into the B-to-A path. A side B write is `byp_flag`=1, `b_en`=1 and `b_write`=1. A later side A read loads `a_dout` with that word. A side A read is `a_cs_n`=0, `a_addr`=3'b001, `a_en`=1 and `a_write`=0.
- R6: A write into a path that still holds an unread word is dropped. The held word is delivered unchanged.
- R7: A read of an empty path leaves the reading side's output register unchanged.
- R8: Side A requests made while bypass is not selected are ignored. Side B requests made while `byp_flag` is 0 are ignored.
- R9: After a read, the path is empty: a second read changes nothing, and a new write is accepted.
- R10: The two paths are independent: words written in both directions at the same time are each delivered to their own reader.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Side A clock |
| clk_b | input | 1 | Side B clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| a_cs_n | input | 1 | Side A chip select, active low |
| a_addr | input | 3 | Side A resource select; 3'b001 selects bypass |
| a_write | input | 1 | Side A direction: 1 write, 0 read |
| a_en | input | 1 | Side A transfer enable |
| a_din | input | WIDTH | Side A write data |
| a_dout | output | WIDTH | Side A output register |
| b_write | input | 1 | Side B direction: 1 write, 0 read |
| b_en | input | 1 | Side B transfer enable |
| b_din | input | WIDTH | Side B write data |
| b_dout | output | WIDTH | Side B output register |
| byp_flag | output | 1 | Bypass mode indication in the `clk_b` domain |

## Verification
The bench builds the bridge with WIDTH=18 and SYNC_STAGES=3. The deeper synchronizer widens the window in which a path is occupied on one side but not yet seen as occupied on the other. Blocked writes and empty reads become reachable there. The clocks run at unrelated periods (10 and 14 time units), so the toggle events cross at shifting phases. A three-stage chain also makes the mode-flag latency bound of R2 and R3 a distinct, countable number of side B edges.

// File: rtl/bypass_pkg.sv
package bypass_pkg;
  localparam logic [2:0] SEL_FIFO   = 3'b000;
  localparam logic [2:0] SEL_BYPASS = 3'b001;

  function automatic logic bypass_selected(input logic cs_n, input logic [2:0] addr);
    return (!cs_n) && (addr == SEL_BYPASS);
  endfunction
endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain;
  logic [STAGES-1:0] chain_nx;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_nx = 1'b1;
    end else begin : g_many
      always_comb chain_nx = {chain[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= chain_nx;
  end

  assign rst_sync_n = chain[STAGES-1];
endmodule

// File: rtl/bit_sync.sv
module bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;
  logic [STAGES-1:0] chain_nx;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_nx = d;
    end else begin : g_many
      always_comb chain_nx = {chain[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= chain_nx;
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/one_word_link.sv
module one_word_link #(
  parameter int WIDTH       = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic             wr_clk,
  input  logic             wr_rst_n,
  input  logic             wr_req,
  input  logic [WIDTH-1:0] wr_data,
  output logic             wr_full,
  output logic [WIDTH-1:0] held_word,
  input  logic             rd_clk,
  input  logic             rd_rst_n,
  input  logic             rd_req,
  output logic             rd_avail,
  output logic [WIDTH-1:0] rd_dout
);
  // writer domain state
  logic             put_tgl, put_tgl_nx;
  logic [WIDTH-1:0] held, held_nx;
  logic             get_tgl_wr;
  logic             wr_fire;

  // reader domain state
  logic             get_tgl, get_tgl_nx;
  logic [WIDTH-1:0] dout, dout_nx;
  logic             put_tgl_rd;
  logic             rd_fire;

  bit_sync #(.STAGES(SYNC_STAGES)) u_get_to_wr (
    .clk(wr_clk), .rst_n(wr_rst_n), .d(get_tgl), .q(get_tgl_wr)
  );
  bit_sync #(.STAGES(SYNC_STAGES)) u_put_to_rd (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(put_tgl), .q(put_tgl_rd)
  );

  always_comb begin
    wr_full    = put_tgl ^ get_tgl_wr;
    wr_fire    = wr_req & ~wr_full;
    put_tgl_nx = put_tgl ^ wr_fire;
    held_nx    = wr_fire ? wr_data : held;
  end

  always_ff @(posedge wr_clk or negedge wr_rst_n) begin
    if (!wr_rst_n) begin
      put_tgl <= 1'b0;
      held    <= '0;
    end else begin
      put_tgl <= put_tgl_nx;
      held    <= held_nx;
    end
  end

  always_comb begin
    rd_avail   = put_tgl_rd ^ get_tgl;
    rd_fire    = rd_req & rd_avail;
    get_tgl_nx = get_tgl ^ rd_fire;
    dout_nx    = rd_fire ? held : dout;
  end

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      get_tgl <= 1'b0;
      dout    <= '0;
    end else begin
      get_tgl <= get_tgl_nx;
      dout    <= dout_nx;
    end
  end

  assign held_word = held;
  assign rd_dout   = dout;
endmodule

// File: rtl/bypass_bridge.sv
module bypass_bridge
  import bypass_pkg::*;
#(
  parameter int WIDTH       = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_a,
  input  logic             clk_b,
  input  logic             rst_n,
  input  logic             a_cs_n,
  input  logic [2:0]       a_addr,
  input  logic             a_write,
  input  logic             a_en,
  input  logic [WIDTH-1:0] a_din,
  output logic [WIDTH-1:0] a_dout,
  input  logic             b_write,
  input  logic             b_en,
  input  logic [WIDTH-1:0] b_din,
  output logic [WIDTH-1:0] b_dout,
  output logic             byp_flag
);
  logic             rst_a_n, rst_b_n;
  logic             a_sel;
  logic             mode_a, mode_a_nx;
  logic             a_wr_req, a_rd_req, b_wr_req, b_rd_req;
  logic             ab_full, ab_avail, ba_full, ba_avail;
  logic [WIDTH-1:0] ab_word, ba_word;

  rst_sync #(.STAGES(2)) u_rst_a (.clk(clk_a), .rst_n(rst_n), .rst_sync_n(rst_a_n));
  rst_sync #(.STAGES(2)) u_rst_b (.clk(clk_b), .rst_n(rst_n), .rst_sync_n(rst_b_n));

  always_comb begin
    a_sel     = bypass_selected(a_cs_n, a_addr);
    mode_a_nx = a_sel;
    a_wr_req  = a_sel & a_en & a_write;
    a_rd_req  = a_sel & a_en & ~a_write;
    b_wr_req  = byp_flag & b_en & b_write;
    b_rd_req  = byp_flag & b_en & ~b_write;
  end

  always_ff @(posedge clk_a or negedge rst_a_n) begin
    if (!rst_a_n) mode_a <= 1'b0;
    else          mode_a <= mode_a_nx;
  end

  bit_sync #(.STAGES(SYNC_STAGES)) u_mode_to_b (
    .clk(clk_b), .rst_n(rst_b_n), .d(mode_a), .q(byp_flag)
  );

  one_word_link #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_a_to_b (
    .wr_clk(clk_a), .wr_rst_n(rst_a_n), .wr_req(a_wr_req), .wr_data(a_din),
    .wr_full(ab_full), .held_word(ab_word),
    .rd_clk(clk_b), .rd_rst_n(rst_b_n), .rd_req(b_rd_req),
    .rd_avail(ab_avail), .rd_dout(b_dout)
  );

  one_word_link #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_b_to_a (
    .wr_clk(clk_b), .wr_rst_n(rst_b_n), .wr_req(b_wr_req), .wr_data(b_din),
    .wr_full(ba_full), .held_word(ba_word),
    .rd_clk(clk_a), .rd_rst_n(rst_a_n), .rd_req(a_rd_req),
    .rd_avail(ba_avail), .rd_dout(a_dout)
  );
endmodule

// File: rtl/bypass_bridge_chk.sv
module bypass_bridge_chk #(
  parameter int WIDTH = 18
) (
  input logic             clk_a,
  input logic             clk_b,
  input logic             rst_a_n,
  input logic             rst_b_n,
  input logic             a_sel,
  input logic             a_en,
  input logic             a_write,
  input logic             b_en,
  input logic             b_write,
  input logic             byp_flag,
  input logic [WIDTH-1:0] a_dout,
  input logic [WIDTH-1:0] b_dout,
  input logic             ab_full,
  input logic [WIDTH-1:0] ab_word,
  input logic             ab_avail,
  input logic             ba_full,
  input logic [WIDTH-1:0] ba_word,
  input logic             ba_avail
);
  // R1: flag held low while the side B domain is in reset
  always @(posedge clk_b) begin
    if (!rst_b_n) begin
      assert_flag_reset_R1: assert (!byp_flag)
        else $error("byp_flag high during reset");
    end
  end

  // R6: an occupied path keeps its word
  assert_ab_hold_R6: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    ab_full |=> $stable(ab_word));
  assert_ba_hold_R6: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    ba_full |=> $stable(ba_word));

  // R7: output registers move only on a read of a non-empty path
  assert_b_quiet_R7: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    !(byp_flag && b_en && !b_write && ab_avail) |=> $stable(b_dout));
  assert_a_quiet_R7: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    !(a_sel && a_en && !a_write && ba_avail) |=> $stable(a_dout));

  // R8: nothing moves on side B while bypass is not signalled
  assert_b_idle_R8: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    !byp_flag |=> $stable(b_dout));
  assert_a_idle_R8: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    !a_sel |=> $stable(a_dout));
endmodule

bind bypass_bridge bypass_bridge_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_a(clk_a), .clk_b(clk_b), .rst_a_n(rst_a_n), .rst_b_n(rst_b_n),
  .a_sel(a_sel), .a_en(a_en), .a_write(a_write), .b_en(b_en), .b_write(b_write),
  .byp_flag(byp_flag), .a_dout(a_dout), .b_dout(b_dout),
  .ab_full(ab_full), .ab_word(ab_word), .ab_avail(ab_avail),
  .ba_full(ba_full), .ba_word(ba_word), .ba_avail(ba_avail)
);

// File: tb/test_bypass_bridge.sv
module test_bypass_bridge;
  localparam int CLK_PERIOD   = 10;
  localparam int CLK_B_PERIOD = 14;
  localparam int W            = 18;
  localparam int SYNC         = 3;

  logic clk_a = 1'b0;
  logic clk_b = 1'b0;
  logic rst_n;
  logic a_cs_n, a_write, a_en, b_write, b_en;
  logic [2:0] a_addr;
  logic [W-1:0] a_din, b_din, a_dout, b_dout;
  logic byp_flag;

  int checks = 0;
  int fails  = 0;

  // bench model
  logic ab_v, ba_v;
  logic [W-1:0] ab_d, ba_d, want_a, want_b;

  always #(CLK_PERIOD/2)   clk_a = ~clk_a;
  always #(CLK_B_PERIOD/2) clk_b = ~clk_b;

  bypass_bridge #(.WIDTH(W), .SYNC_STAGES(SYNC)) i_bypass_bridge (
    .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
    .a_cs_n(a_cs_n), .a_addr(a_addr), .a_write(a_write), .a_en(a_en),
    .a_din(a_din), .a_dout(a_dout),
    .b_write(b_write), .b_en(b_en), .b_din(b_din), .b_dout(b_dout),
    .byp_flag(byp_flag)
  );

  function automatic logic [W-1:0] after_read(input logic valid, input logic [W-1:0] held,
                                               input logic [W-1:0] old);
    return valid ? held : old;
  endfunction

  function automatic logic [W-1:0] rand_word();
    return W'($urandom);
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] want);
    checks++;
    if (act !== want) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, want);
    end
  endtask

  task automatic a_mode(input logic cs_n, input logic [2:0] addr);
    @(negedge clk_a);
    a_cs_n = cs_n;
    a_addr = addr;
  endtask

  task automatic a_op(input logic wr, input logic [W-1:0] d);
    @(negedge clk_a);
    a_en = 1'b1; a_write = wr; a_din = d;
    @(negedge clk_a);
    a_en = 1'b0;
  endtask

  task automatic b_op(input logic wr, input logic [W-1:0] d);
    @(negedge clk_b);
    b_en = 1'b1; b_write = wr; b_din = d;
    @(negedge clk_b);
    b_en = 1'b0;
  endtask

  task automatic settle();
    repeat (8) @(negedge clk_b);
    repeat (8) @(negedge clk_a);
  endtask

  // model-tracked operations
  task automatic m_a_write(input logic [W-1:0] d);
    a_op(1'b1, d);
    if (!ab_v) begin ab_v = 1'b1; ab_d = d; end
    settle();
  endtask
  task automatic m_b_write(input logic [W-1:0] d);
    b_op(1'b1, d);
    if (!ba_v) begin ba_v = 1'b1; ba_d = d; end
    settle();
  endtask
  task automatic m_b_read();
    b_op(1'b0, '0);
    want_b = after_read(ab_v, ab_d, want_b);
    ab_v = 1'b0;
    settle();
  endtask
  task automatic m_a_read();
    a_op(1'b0, '0);
    want_a = after_read(ba_v, ba_d, want_a);
    ba_v = 1'b0;
    settle();
  endtask

  initial begin
    repeat (100000) @(posedge clk_a);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1B5E_0A77));
    rst_n = 1'b0;
    a_cs_n = 1'b1; a_addr = 3'b000; a_write = 1'b0; a_en = 1'b0; a_din = '0;
    b_write = 1'b0; b_en = 1'b0; b_din = '0;
    ab_v = 1'b0; ba_v = 1'b0; ab_d = '0; ba_d = '0; want_a = '0; want_b = '0;

    repeat (4) @(negedge clk_b);
    chk("R1 flag in reset", W'(byp_flag), '0);
    chk("R1 a_dout in reset", a_dout, '0);
    chk("R1 b_dout in reset", b_dout, '0);
    @(negedge clk_a);
    rst_n = 1'b1;
    settle();

    // R3: FIFO address keeps the flag low
    a_mode(1'b0, 3'b000);
    settle();
    chk("R3 flag low for address 000", W'(byp_flag), '0);

    // R2: latency bound of flag assertion
    a_mode(1'b0, 3'b001);
    @(posedge clk_a);
    repeat (SYNC + 1) @(negedge clk_b);
    chk("R2 flag raised within bound", W'(byp_flag), W'(1));

    // R4 / R5 basic transfers
    m_a_write(18'h2A5C3);
    m_b_read();
    chk("R4 A to B word", b_dout, want_b);
    m_b_write(18'h1F00E);
    m_a_read();
    chk("R5 B to A word", a_dout, want_a);

    // R6 blocked second write, R9 empty after read then accepts
    m_a_write(18'h00111);
    m_a_write(18'h3FFFF);
    m_b_read();
    chk("R6 held word survives second write", b_dout, 18'h00111);
    m_b_read();
    chk("R9 second read changes nothing", b_dout, 18'h00111);
    m_a_write(18'h0ABCD);
    m_b_read();
    chk("R9 new write accepted after read", b_dout, 18'h0ABCD);

    // R7 empty read on side A
    m_a_read();
    chk("R7 empty read keeps a_dout", a_dout, 18'h1F00E);

    // R3 / R8 outside bypass
    a_mode(1'b0, 3'b000);
    @(posedge clk_a);
    repeat (SYNC + 1) @(negedge clk_b);
    chk("R3 flag dropped within bound", W'(byp_flag), '0);
    a_op(1'b1, 18'h15555);
    b_op(1'b1, 18'h2AAAA);
    a_mode(1'b1, 3'b001);
    settle();
    chk("R3 flag low with chip select high", W'(byp_flag), '0);
    b_op(1'b0, '0);
    a_op(1'b0, '0);
    a_mode(1'b0, 3'b001);
    settle();
    m_b_read();
    chk("R8 ignored A write not delivered", b_dout, 18'h0ABCD);
    m_a_read();
    chk("R8 ignored B write not delivered", a_dout, 18'h1F00E);

    // R10 both directions at once
    fork
      a_op(1'b1, 18'h12345);
      b_op(1'b1, 18'h0FEDC);
    join
    ab_v = 1'b1; ab_d = 18'h12345; ba_v = 1'b1; ba_d = 18'h0FEDC;
    settle();
    m_b_read();
    m_a_read();
    chk("R10 A to B independent", b_dout, 18'h12345);
    chk("R10 B to A independent", a_dout, 18'h0FEDC);

    // random mix against the model
    for (int i = 0; i < 150; i++) begin
      int act;
      act = $urandom_range(0, 4);
      case (act)
        0: m_a_write(rand_word());
        1: m_a_read();
        2: m_b_write(rand_word());
        3: m_b_read();
        default: begin
          a_mode(1'b0, 3'b000);
          settle();
          chk("R3 random mode exit", W'(byp_flag), '0);
          a_op(1'b1, rand_word());
          a_op(1'b0, '0);
          b_op(1'b1, rand_word());
          b_op(1'b0, '0);
          a_mode(1'b0, 3'b001);
          settle();
          chk("R2 random mode entry", W'(byp_flag), W'(1));
        end
      endcase
      chk("R4 R6 R7 R8 random b_dout", b_dout, want_b);
      chk("R5 R6 R7 R8 random a_dout", a_dout, want_a);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule